// File: doc/BRIEF.md
# Write-Only I2C Configuration Slave

This block lets a host on an I2C bus load one 16-bit control word into a proximity-sensing engine. It samples SCL and SDA with a fast system clock, finds START, repeated START and STOP conditions, and matches a fixed 7-bit address. It acknowledges each accepted byte by enabling an open-drain pull-down on SDA. The block has no read path and no register pointer. A transfer is always one address byte with the write bit, then the low data byte, then the high data byte. The new word takes effect all at once after the high byte has been acknowledged.

The word is also decoded into named fields that drive the sensing engine directly. These fields are the run trigger, the power enable, the pulse count per burst, the pulse rate, the burst-to-idle ratio, the comparator threshold and the filter resistor select. All outputs are plain levels, so there is no back-pressure toward the engine. On the bus side the block never holds SCL low. The system clock must be fast enough to oversample SCL at up to 400 kHz: at least about 20 system clocks per SCL period.

Top module: `cfg_i2c_wr_slave`

## Requirements
- R1: After reset `cfg_word` equals 16'h0490 and `sda_pull` is 0.
- R2: The field outputs are slices of `cfg_word`:
  - `sense_run` = bit 15, `power_on` = bit 14
  - `burst_sel` = bits 13:10, `rate_sel` = bits 9:8
  - `duty_sel` = bits 7:6, `thresh_sel` = bits 5:2
  - `filter_sel` = bits 1:0
- R3: An address byte is acknowledged only when all of these hold:
  - its 7 MSB-first address bits equal 7'b1010100, and its eighth bit (R/W) is 0;
  - the acknowledge is `sda_pull` high while SCL is high in the ninth clock.
  Every other address value, and the matching address with R/W = 1, leaves SDA released in that ninth clock.
- R4: After a byte is not acknowledged, later bytes are not acknowledged and `cfg_word` does not change until the next START or STOP.
- R5: After an acknowledged address, the first data byte sent (MSB first) becomes `cfg_word[7:0]` and the second becomes `cfg_word[15:8]`. Each data byte is acknowledged.
- R6: `cfg_word` changes only at the end of the ninth clock of the second data byte. A STOP after only the first data byte leaves `cfg_word` unchanged.
- R7: A repeated START at any point restarts address reception, and any partly received transfer is discarded.
- R8: Any byte after the second data byte is not acknowledged, and it does not alter `cfg_word`.
- R9: `sda_pull` rises only after an SCL falling edge that ends an accepted byte. It falls only after an SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| sda_pull | output | 1 | Enable for the open-drain SDA pull-down |
| cfg_word | output | 16 | Committed control word |
| sense_run | output | 1 | Run trigger for the sensing engine |
| power_on | output | 1 | Power enable for the sensing engine |
| burst_sel | output | 4 | Pulse count per burst select |
| rate_sel | output | 2 | Pulse rate select |
| duty_sel | output | 2 | Burst-to-idle ratio select |
| thresh_sel | output | 4 | Comparator threshold select |
| filter_sel | output | 2 | Filter resistor select |

## Verification
A wrong bit counter or a misaligned shift register shows up at the ports within one byte. It appears as an acknowledge in the wrong clock or as a byte committed shifted, and it is caught by the ninth-clock sample and the word compare that follow each transfer. A control state that fails to leave its ignore condition, or fails to restart on a repeated START, shows up as a missing acknowledge on the very next address byte. A commit made too early or duplicated changes `cfg_word` after a truncated or over-long transfer. This is visible as soon as the STOP has passed through the synchronizer, a few system clocks later.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  localparam int CFG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ACK   = 2'd2,
    ST_SKIP  = 2'd3
  } link_state_t;

  typedef enum logic [1:0] {
    SLOT_ADDR = 2'd0,
    SLOT_LOW  = 2'd1,
    SLOT_HIGH = 2'd2,
    SLOT_OVER = 2'd3
  } byte_slot_t;

  typedef struct packed {
    logic       run;
    logic       power;
    logic [3:0] burst;
    logic [1:0] rate;
    logic [1:0] duty;
    logic [3:0] thresh;
    logic [1:0] filter;
  } cfg_fields_t;

  function automatic cfg_fields_t split_cfg(input logic [CFG_W-1:0] w);
    return cfg_fields_t'(w);
  endfunction

endpackage

// File: rtl/cfg_i2c_bus_sync.sv
module cfg_i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_sh;
  logic [LAST:0] sda_sh;
  logic          scl_prev;
  logic          sda_prev;
  logic          scl_now;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_raw;
          sda_sh <= sda_raw;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[LAST-1:0], scl_raw};
          sda_sh <= {sda_sh[LAST-1:0], sda_raw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_sh[LAST];
      sda_prev <= sda_sh[LAST];
    end
  end

  assign scl_now   = scl_sh[LAST];
  assign sda_lvl   = sda_sh[LAST];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/cfg_i2c_link.sv
module cfg_i2c_link
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              ignoring,
  output logic              low_load,
  output logic              commit,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

  link_state_t      state;
  byte_slot_t       slot;
  logic [CNT_W-1:0] bit_cnt;
  logic             full;
  logic             pend_commit;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      slot        <= SLOT_ADDR;
      bit_cnt     <= '0;
      full        <= 1'b0;
      pend_commit <= 1'b0;
      shreg       <= '0;
      sda_pull    <= 1'b0;
      low_load    <= 1'b0;
      commit      <= 1'b0;
    end else begin
      low_load <= 1'b0;
      commit   <= 1'b0;
      if (start_det) begin
        state       <= ST_SHIFT;
        slot        <= SLOT_ADDR;
        bit_cnt     <= '0;
        full        <= 1'b0;
        pend_commit <= 1'b0;
        sda_pull    <= 1'b0;
      end else if (stop_det) begin
        state       <= ST_IDLE;
        full        <= 1'b0;
        pend_commit <= 1'b0;
        sda_pull    <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: begin
            if (scl_rise && !full) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              if (bit_cnt == LAST_BIT) full <= 1'b1;
              else bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && full) begin
              full    <= 1'b0;
              bit_cnt <= '0;
              case (slot)
                SLOT_ADDR: begin
                  if (shreg == ADDR_WR) begin
                    sda_pull <= 1'b1;
                    state    <= ST_ACK;
                    slot     <= SLOT_LOW;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                SLOT_LOW: begin
                  low_load <= 1'b1;
                  sda_pull <= 1'b1;
                  state    <= ST_ACK;
                  slot     <= SLOT_HIGH;
                end
                SLOT_HIGH: begin
                  pend_commit <= 1'b1;
                  sda_pull    <= 1'b1;
                  state       <= ST_ACK;
                  slot        <= SLOT_OVER;
                end
                default: state <= ST_SKIP;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull    <= 1'b0;
              state       <= ST_SHIFT;
              commit      <= pend_commit;
              pend_commit <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ignoring = (state == ST_SKIP);
  assign rx_byte  = shreg;

endmodule

// File: rtl/cfg_i2c_word_reg.sv
module cfg_i2c_word_reg
  import cfg_i2c_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VALUE = 16'h0490
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               low_load,
  input  logic               commit,
  input  logic [BYTE_W-1:0]  rx_byte,
  output logic [CFG_W-1:0]   cfg_word
);

  logic [BYTE_W-1:0] low_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_stage <= RESET_VALUE[BYTE_W-1:0];
      cfg_word  <= RESET_VALUE;
    end else begin
      if (low_load) low_stage <= rx_byte;
      if (commit)   cfg_word  <= {rx_byte, low_stage};
    end
  end

endmodule

// File: rtl/cfg_i2c_wr_slave.sv
module cfg_i2c_wr_slave
  import cfg_i2c_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [6:0]       DEV_ADDR    = 7'b1010100,
  parameter logic [15:0]      RESET_VALUE = 16'h0490
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_pull,
  output logic [15:0] cfg_word,
  output logic        sense_run,
  output logic        power_on,
  output logic [3:0]  burst_sel,
  output logic [1:0]  rate_sel,
  output logic [1:0]  duty_sel,
  output logic [3:0]  thresh_sel,
  output logic [1:0]  filter_sel
);

  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              ignoring;
  logic              low_load;
  logic              commit;
  logic [BYTE_W-1:0] rx_byte;
  cfg_fields_t       fields;

  cfg_i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfg_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .ignoring  (ignoring),
    .low_load  (low_load),
    .commit    (commit),
    .rx_byte   (rx_byte)
  );

  cfg_i2c_word_reg #(.RESET_VALUE(RESET_VALUE)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .low_load (low_load),
    .commit   (commit),
    .rx_byte  (rx_byte),
    .cfg_word (cfg_word)
  );

  assign fields     = split_cfg(cfg_word);
  assign sense_run  = fields.run;
  assign power_on   = fields.power;
  assign burst_sel  = fields.burst;
  assign rate_sel   = fields.rate;
  assign duty_sel   = fields.duty;
  assign thresh_sel = fields.thresh;
  assign filter_sel = fields.filter;

endmodule

// File: rtl/cfg_i2c_wr_checker.sv
module cfg_i2c_wr_checker #(
  parameter logic [15:0] RESET_VALUE = 16'h0490
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_pull,
  input logic        scl_fall,
  input logic        start_det,
  input logic        stop_det,
  input logic        commit,
  input logic        ignoring,
  input logic [15:0] cfg_word
);

  // R1: word held at its default while reset is applied
  assert_reset_word_R1: assert property (@(posedge clk)
    !rst_n |=> (cfg_word == RESET_VALUE));

  // R6: no change of the word without a commit the cycle before
  assert_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(cfg_word));

  // R4: never acknowledge while skipping
  assert_skip_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_pull);

  // R7: a START always releases SDA
  assert_start_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  // R9: pull-down asserts only after an SCL falling edge
  assert_pull_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R9: pull-down drops only after SCL fall, START or STOP
  assert_pull_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

endmodule

bind cfg_i2c_wr_slave cfg_i2c_wr_checker #(.RESET_VALUE(RESET_VALUE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull  (sda_pull),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .commit    (commit),
  .ignoring  (ignoring),
  .cfg_word  (cfg_word)
);

// File: tb/cfg_i2c_wr_slave_test.sv
module cfg_i2c_wr_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam logic [6:0] ADDR = 7'b1010100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull;
  logic [15:0] cfg_word;
  logic        sense_run, power_on;
  logic [3:0]  burst_sel, thresh_sel;
  logic [1:0]  rate_sel, duty_sel, filter_sel;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_wr_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .sda_pull   (sda_pull),
    .cfg_word   (cfg_word),
    .sense_run  (sense_run),
    .power_on   (power_on),
    .burst_sel  (burst_sel),
    .rate_sel   (rate_sel),
    .duty_sel   (duty_sel),
    .thresh_sel (thresh_sel),
    .filter_sel (filter_sel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b1; tick(2*QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(QTR);
      scl_m = 1'b1; tick(2*QTR);
      scl_m = 1'b0; tick(QTR);
    end
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    ack = ~sda_line;
    tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic check_fields(input logic [15:0] w, input string req);
    check(sense_run == w[15], req, sense_run, w[15]);
    check(power_on == w[14], req, power_on, w[14]);
    check(burst_sel == w[13:10], req, burst_sel, w[13:10]);
    check(rate_sel == w[9:8], req, rate_sel, w[9:8]);
    check(duty_sel == w[7:6], req, duty_sel, w[7:6]);
    check(thresh_sel == w[5:2], req, thresh_sel, w[5:2]);
    check(filter_sel == w[1:0], req, filter_sel, w[1:0]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit a0, a1, a2, a3;
    logic [15:0] expw;
    logic [7:0] lo, hi;
    tick(4);
    // R1 reset state
    check(cfg_word == 16'h0490, "R1 reset word", cfg_word, 16'h0490);
    check(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
    check_fields(16'h0490, "R2 reset fields");
    rst_n = 1'b1;
    tick(4);

    // R3 address sweep with write bit, and matching address with read bit
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, a0);
      bus_stop();
      check(a0 == (a[6:0] == ADDR), "R3 address match", a0, (a[6:0] == ADDR));
    end
    bus_start();
    send_byte({ADDR, 1'b1}, a0);
    bus_stop();
    check(a0 == 1'b0, "R3 read bit nack", a0, 0);
    check(cfg_word == 16'h0490, "R3 word untouched", cfg_word, 16'h0490);

    // R5 / R2 full writes over many patterns
    expw = 16'h0490;
    for (int i = 0; i < 24; i++) begin
      lo = 8'((i * 37 + 5) & 255);
      hi = 8'((i * 91 + 13) & 255);
      bus_start();
      send_byte({ADDR, 1'b0}, a0);
      send_byte(lo, a1);
      send_byte(hi, a2);
      bus_stop();
      expw = {hi, lo};
      check(a0 && a1 && a2, "R5 acks", {a0, a1, a2}, 3'b111);
      check(cfg_word == expw, "R5 word", cfg_word, expw);
      check_fields(expw, "R2 fields");
    end

    // R6 stop after low byte only
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'hA5, a1);
    check(cfg_word == expw, "R6 no early update", cfg_word, expw);
    bus_stop();
    check(cfg_word == expw, "R6 truncated transfer", cfg_word, expw);

    // R4 wrong address followed by data
    bus_start();
    send_byte({7'b1010101, 1'b0}, a0);
    send_byte(8'h12, a1);
    send_byte(8'h34, a2);
    bus_stop();
    check({a0, a1, a2} == 3'b000, "R4 no acks", {a0, a1, a2}, 0);
    check(cfg_word == expw, "R4 word kept", cfg_word, expw);

    // R7 repeated start after low byte
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h11, a1);
    bus_start();
    send_byte({ADDR, 1'b0}, a2);
    send_byte(8'h3C, a3);
    send_byte(8'hC3, a1);
    bus_stop();
    expw = 16'hC33C;
    check(a2 && a3 && a1, "R7 acks after restart", {a2, a3, a1}, 3'b111);
    check(cfg_word == expw, "R7 restart word", cfg_word, expw);

    // R7 repeated start after a rejected address
    bus_start();
    send_byte({7'b0001111, 1'b0}, a0);
    bus_start();
    send_byte({ADDR, 1'b0}, a1);
    send_byte(8'h5A, a2);
    send_byte(8'h81, a3);
    bus_stop();
    expw = 16'h815A;
    check(!a0 && a1, "R7 restart after nack", {a0, a1}, 2'b01);
    check(cfg_word == expw, "R7 word after restart", cfg_word, expw);

    // R8 extra byte
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h0F, a1);
    send_byte(8'hF0, a2);
    send_byte(8'hEE, a3);
    check(a3 == 1'b0, "R8 extra byte nack", a3, 0);
    check(sda_pull == 1'b0, "R9 released after nack", sda_pull, 0);
    bus_stop();
    expw = 16'hF00F;
    check(cfg_word == expw, "R8 word kept", cfg_word, expw);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule